// File: doc/BRIEF.md
# Transmit Serializer with Byte-Rate Clock

The block turns parallel words into a serial bit stream. It runs on the transmit bit clock. An internal position counter divides that clock down to a byte-rate clock and produces a load instant at every word boundary. A parallel word from upstream logic is taken into a capture register on each rising edge of its word strobe. The strobe is sampled as an ordinary input in the bit-clock domain. At every word boundary the capture register is copied into a shift register, which then sends the word most significant bit first, one bit per clock. The next word follows with no idle bit.

A narrow mode sends only the upper half of each word, so the word period is halved. A line loopback select, active low, replaces the serial output with the receive serial data. A self-check mode loads a known byte sequence in place of the captured data. It compares the line output against the stream that sequence should produce and raises a sticky error flag on any difference. After reset the captured path counts as valid only once the strobe has risen twice. Until then, zero words are sent.

Top module: `txser_top`

## Requirements
- R1: A word is taken into the capture register on a clock edge where `word_strobe` is sampled high and was sampled low on the previous edge. That word is sent at every word boundary until the next such rising edge, so a strobe held high repeats the last word.
- R2: In wide mode (`narrow_sel`=0) each word occupies 8 consecutive clock cycles on `ser_out`, bit 7 first and bit 0 last. Consecutive words follow each other with no gap or repeated bit.
- R3: In narrow mode (`narrow_sel`=1) each word occupies 4 cycles and sends bits 7, 6, 5, 4 in that order. `narrow_sel` is changed only while reset is asserted.
- R4: `byte_clk` has a period of 8 cycles (4 in narrow mode). It is high for the first half of each word, and rises in the cycle that carries the first bit of a word. `load_pulse` is high for exactly that one cycle of each word.
- R5: While `rst_n` is low, `byte_clk`, `load_pulse`, `selftest_err` and the shift register are held at 0. The first word boundary comes at the first clock edge after reset is released.
- R6: After reset, every word sent before the second rising edge of `word_strobe` is all zeros. The word captured at that second edge is the first one transmitted.
- R7: When `lpbk_n` is 0, `ser_out` follows `rx_ser` in the same cycle. The serializer keeps running underneath.
- R8: While `selftest_en` is 1, the words loaded are a sequence starting at 8'hC3 and increasing by 8'h35 (mod 256) per word. The sequence restarts at 8'hC3 whenever `selftest_en` is 0. `selftest_err` is set one cycle after a `ser_out` bit differs from the expected bit of a word loaded in self-check mode. It stays set while `selftest_en` is 1 and reads 0 one cycle after `selftest_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_word | input | 8 | Parallel word from upstream |
| word_strobe | input | 1 | Word strobe; its rising edge captures `par_word` |
| narrow_sel | input | 1 | 1 selects the 4-bit word mode |
| lpbk_n | input | 1 | Line loopback, active low |
| rx_ser | input | 1 | Receive serial data used in loopback |
| selftest_en | input | 1 | Enables the self-check mode |
| ser_out | output | 1 | Serial line output |
| byte_clk | output | 1 | Byte-rate clock |
| load_pulse | output | 1 | Marks the first bit of each word |
| selftest_err | output | 1 | Sticky self-check mismatch flag |

## Verification
The bench targets the start after reset. If the counter started at the wrong phase, the first word would be shifted by one bit. If the design did not wait for the two strobe edges, stale capture contents would leak onto the line before zeros were due. It also holds the strobe high across several word boundaries, which exposes a level-sensitive capture, and runs in narrow mode, where an off-by-one wrap would send one lower bit or leave a gap. In self-check mode, looping a constant level back into the line must set the error flag, and dropping the enable must clear it. A design that compared the shift register instead of the line output would never flag that mismatch.

// File: rtl/txser_pkg.sv
package txser_pkg;
    localparam int unsigned DEF_DATA_W = 8;

    function automatic int unsigned cnt_bits(input int unsigned w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction
endpackage

// File: rtl/txser_byteclk.sv
module txser_byteclk
    import txser_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned CNT_W = cnt_bits(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow_sel,
    output logic [CNT_W-1:0] pos,
    output logic             word_end,
    output logic             byte_clk,
    output logic             load_pulse
);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W / 2 - 1);
    localparam logic [CNT_W-1:0] HALF_WIDE   = CNT_W'(DATA_W / 2);
    localparam logic [CNT_W-1:0] HALF_NARROW = CNT_W'(DATA_W / 4);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             bclk;
        logic             load;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] half_idx;
    logic             at_end;

    always_comb begin
        last_idx = narrow_sel ? LAST_NARROW : LAST_WIDE;
        half_idx = narrow_sel ? HALF_NARROW : HALF_WIDE;
        at_end   = (st_q.pos >= last_idx);
        st_d     = st_q;
        if (at_end) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + CNT_W'(1);
        end
        st_d.bclk = (st_d.pos < half_idx);
        st_d.load = at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos  <= LAST_WIDE;
            st_q.bclk <= 1'b0;
            st_q.load <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos        = st_q.pos;
    assign word_end   = at_end;
    assign byte_clk   = st_q.bclk;
    assign load_pulse = st_q.load;
endmodule

// File: rtl/txser_capture.sv
module txser_capture
    import txser_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_sel,
    input  logic              word_strobe,
    input  logic [DATA_W-1:0] par_word,
    output logic [DATA_W-1:0] cap_word,
    output logic              cap_valid
);
    localparam int unsigned HALF = DATA_W / 2;

    typedef struct packed {
        logic              strb;
        logic [1:0]        edges;
        logic [DATA_W-1:0] word;
    } state_t;

    state_t st_d, st_q;
    logic              rise;
    logic [DATA_W-1:0] keep_mask;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_mask
            if (b >= HALF) begin : g_hi
                assign keep_mask[b] = 1'b1;
            end else begin : g_lo
                assign keep_mask[b] = ~narrow_sel;
            end
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        rise      = word_strobe & ~st_q.strb;
        st_d.strb = word_strobe;
        if (rise) begin
            st_d.word = par_word & keep_mask;
            if (st_q.edges != 2'd2) begin
                st_d.edges = st_q.edges + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_word  = st_q.word;
    assign cap_valid = (st_q.edges == 2'd2);
endmodule

// File: rtl/txser_shift.sv
module txser_shift
    import txser_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_end,
    input  logic [DATA_W-1:0] load_word,
    input  logic              lpbk_n,
    input  logic              rx_ser,
    output logic              ser_out
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (word_end) begin
            st_d.sh = load_word;
        end else begin
            st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = lpbk_n ? st_q.sh[DATA_W-1] : rx_ser;
endmodule

// File: rtl/txser_selfchk.sv
module txser_selfchk
    import txser_pkg::*;
#(
    parameter int unsigned       DATA_W   = DEF_DATA_W,
    parameter logic [DATA_W-1:0] PAT_SEED = DATA_W'(8'hC3),
    parameter logic [DATA_W-1:0] PAT_STEP = DATA_W'(8'h35),
    localparam int unsigned      CNT_W    = cnt_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              word_end,
    input  logic [CNT_W-1:0]  pos,
    input  logic              ser_line,
    output logic [DATA_W-1:0] pat_word,
    output logic              err
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] pat;
        logic [DATA_W-1:0] expect_word;
        logic              armed;
        logic              err;
    } state_t;

    state_t st_d, st_q;
    logic   want_bit;
    logic   miss;

    always_comb begin
        st_d     = st_q;
        want_bit = st_q.expect_word[TOP_IDX - pos];
        miss     = st_q.armed & (ser_line != want_bit);
        if (!enable) begin
            st_d.pat = PAT_SEED;
            st_d.err = 1'b0;
        end else begin
            st_d.err = st_q.err | miss;
            if (word_end) begin
                st_d.pat = st_q.pat + PAT_STEP;
            end
        end
        if (word_end) begin
            st_d.expect_word = st_q.pat;
            st_d.armed       = enable;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pat         <= PAT_SEED;
            st_q.expect_word <= '0;
            st_q.armed       <= 1'b0;
            st_q.err         <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat_word = st_q.pat;
    assign err      = st_q.err;
endmodule

// File: rtl/txser_top.sv
module txser_top
    import txser_pkg::*;
#(
    parameter int unsigned       DATA_W   = DEF_DATA_W,
    parameter logic [DATA_W-1:0] PAT_SEED = DATA_W'(8'hC3),
    parameter logic [DATA_W-1:0] PAT_STEP = DATA_W'(8'h35)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] par_word,
    input  logic              word_strobe,
    input  logic              narrow_sel,
    input  logic              lpbk_n,
    input  logic              rx_ser,
    input  logic              selftest_en,
    output logic              ser_out,
    output logic              byte_clk,
    output logic              load_pulse,
    output logic              selftest_err
);
    localparam int unsigned CNT_W = cnt_bits(DATA_W);

    logic [CNT_W-1:0]  pos;
    logic              word_end;
    logic [DATA_W-1:0] cap_word;
    logic              cap_valid;
    logic [DATA_W-1:0] pat_word;
    logic [DATA_W-1:0] load_word;

    txser_byteclk #(.DATA_W(DATA_W)) u_bclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .narrow_sel (narrow_sel),
        .pos        (pos),
        .word_end   (word_end),
        .byte_clk   (byte_clk),
        .load_pulse (load_pulse)
    );

    txser_capture #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .narrow_sel  (narrow_sel),
        .word_strobe (word_strobe),
        .par_word    (par_word),
        .cap_word    (cap_word),
        .cap_valid   (cap_valid)
    );

    always_comb begin
        if (selftest_en) begin
            load_word = pat_word;
        end else if (cap_valid) begin
            load_word = cap_word;
        end else begin
            load_word = '0;
        end
    end

    txser_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_end  (word_end),
        .load_word (load_word),
        .lpbk_n    (lpbk_n),
        .rx_ser    (rx_ser),
        .ser_out   (ser_out)
    );

    txser_selfchk #(
        .DATA_W   (DATA_W),
        .PAT_SEED (PAT_SEED),
        .PAT_STEP (PAT_STEP)
    ) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (selftest_en),
        .word_end (word_end),
        .pos      (pos),
        .ser_line (ser_out),
        .pat_word (pat_word),
        .err      (selftest_err)
    );
endmodule

// File: rtl/txser_props.sv
module txser_props (
    input logic clk,
    input logic rst_n,
    input logic narrow_sel,
    input logic selftest_en,
    input logic byte_clk,
    input logic load_pulse,
    input logic selftest_err
);
    // R4: a word start lies in the high half of the byte clock
    p_load_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> byte_clk);

    // R4: every rise of the byte clock coincides with a word start
    p_rise_is_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk) |-> load_pulse);

    // R3: narrow words still span more than one cycle
    p_narrow_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && narrow_sel) |=> !load_pulse);

    // R8: error is sticky while self-check stays enabled
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_err && selftest_en) |=> selftest_err);

    // R8: error clears once self-check is disabled
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !selftest_en |=> !selftest_err);
endmodule

bind txser_top txser_props u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .narrow_sel   (narrow_sel),
    .selftest_en  (selftest_en),
    .byte_clk     (byte_clk),
    .load_pulse   (load_pulse),
    .selftest_err (selftest_err)
);

// File: tb/txser_top_test.sv
module txser_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] par_word = 8'h00;
    logic       word_strobe = 1'b0;
    logic       narrow_sel = 1'b0;
    logic       lpbk_n = 1'b1;
    logic       rx_ser = 1'b0;
    logic       selftest_en = 1'b0;
    logic       ser_out, byte_clk, load_pulse, selftest_err;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    txser_top uut (
        .clk(clk), .rst_n(rst_n), .par_word(par_word), .word_strobe(word_strobe),
        .narrow_sel(narrow_sel), .lpbk_n(lpbk_n), .rx_ser(rx_ser),
        .selftest_en(selftest_en), .ser_out(ser_out), .byte_clk(byte_clk),
        .load_pulse(load_pulse), .selftest_err(selftest_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int         m_pos = 7;
    int         m_edges = 0;
    bit         m_prev = 0;
    bit   [7:0] m_cap = 0;
    bit   [7:0] m_word = 0;
    bit   [7:0] m_pat = 8'hC3;
    bit         m_armed = 0;
    bit         m_err = 0;
    bit         m_bc = 0;
    bit         m_ld = 0;

    always @(posedge clk) begin
        int  w;
        bit  line;
        bit  last;
        bit  [7:0] src;
        if (!rst_n) begin
            m_pos = 7; m_edges = 0; m_prev = 0; m_cap = 0; m_word = 0;
            m_pat = 8'hC3; m_armed = 0; m_err = 0; m_bc = 0; m_ld = 0;
        end else begin
            w = narrow_sel ? 4 : 8;
            line = lpbk_n ? m_word[7 - m_pos] : rx_ser;
            if (!selftest_en) m_err = 0;
            else if (m_armed && line != m_word[7 - m_pos]) m_err = 1;
            last = (m_pos >= w - 1);
            src = selftest_en ? m_pat : ((m_edges == 2) ? m_cap : 8'h00);
            if (word_strobe && !m_prev) begin
                m_cap = narrow_sel ? {par_word[7:4], 4'h0} : par_word;
                if (m_edges < 2) m_edges++;
            end
            m_prev = word_strobe;
            if (last) begin
                m_word = src;
                m_armed = selftest_en;
                m_pos = 0;
                if (selftest_en) m_pat = m_pat + 8'h35;
            end else begin
                m_pos++;
            end
            if (!selftest_en) m_pat = 8'hC3;
            m_bc = (m_pos < w / 2);
            m_ld = last;
        end
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        string t;
        bit    exp_ser;
        if (!done) begin
            cycles++;
            exp_ser = lpbk_n ? m_word[7 - m_pos] : rx_ser;
            if (!rst_n) t = "R5";
            else if (!lpbk_n) t = "R7";
            else if (m_armed) t = "R8";
            else if (m_edges < 2) t = "R6";
            else if (narrow_sel) t = "R3";
            else t = "R2";
            check(t, "ser_out", int'(ser_out), int'(exp_ser));
            check(rst_n ? "R4" : "R5", "byte_clk", int'(byte_clk), int'(m_bc));
            check(rst_n ? "R4" : "R5", "load_pulse", int'(load_pulse), int'(m_ld));
            check(rst_n ? "R8" : "R5", "selftest_err", int'(selftest_err), int'(m_err));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // one word per period, strobe high for the first half (R1)
    task automatic feed(input int words, input int period, input bit [7:0] seed);
        bit [7:0] v;
        v = seed;
        for (int i = 0; i < words; i++) begin
            par_word = v;
            word_strobe = 1'b1;
            tick(period / 2);
            word_strobe = 1'b0;
            tick(period - period / 2);
            v = v * 8'd5 + 8'd17;
        end
    endtask

    task automatic do_reset(input bit narrow);
        rst_n = 1'b0;
        narrow_sel = narrow;
        tick(4);
        rst_n = 1'b1;
    endtask

    initial begin
        tick(1);
        do_reset(1'b0);
        // R6: single strobe edge, zeros must continue
        par_word = 8'hFF; word_strobe = 1'b1; tick(3); word_strobe = 1'b0;
        tick(30);
        // R1 R2: streaming words with a strobe phase unrelated to the boundary
        feed(20, 8, 8'h5A);
        feed(10, 11, 8'h81);
        // R1: strobe held high repeats the last word
        par_word = 8'h96; word_strobe = 1'b1; tick(40);
        par_word = 8'h0F; tick(10); word_strobe = 1'b0; tick(10);
        // R7: loopback with toggling receive data
        lpbk_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            rx_ser = i[0] ^ i[2];
            tick(1);
        end
        lpbk_n = 1'b1; rx_ser = 1'b0;
        tick(5);
        // R8: clean self-check run
        selftest_en = 1'b1; tick(100);
        // R8: loop a constant level in while checking: error expected
        lpbk_n = 1'b0; rx_ser = 1'b1; tick(20);
        lpbk_n = 1'b1; rx_ser = 1'b0; tick(20);
        selftest_en = 1'b0; tick(12);
        selftest_en = 1'b1; tick(40);
        selftest_en = 1'b0; tick(5);
        // R3: narrow mode
        do_reset(1'b1);
        feed(2, 4, 8'hE7);
        feed(30, 4, 8'h3C);
        feed(10, 7, 8'hB2);
        selftest_en = 1'b1; tick(40);
        selftest_en = 1'b0; tick(8);
        // R5: reset mid-stream
        rst_n = 1'b0; tick(6);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule